// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block holds the digital control for one 8-bit I/O port. Software writes an output latch and two per-pin configuration vectors. Together, the configuration bits pick one of four drive types for each pin. The block turns each pin's type and latch bit into pad enables: strong pull-down, strong pull-up and weak pull-up. It also produces a digital input enable for each pin.

Some restrictions are fixed in hardware and cannot be changed by software. Pin 5 is always an input. Pins 2 and 3 can only be open-drain or input-only. Pins 1 to 5 can have their digital input gated off, so that a pin can serve an analog function.

Pad inputs pass through a synchronizer and can be read back on the register bus. Reads are combinational from the address. Writes take effect on the clock edge on which `busWrEn` is high.

Top module: `gpioPortCtl`

## Requirements
- R1: After reset, the latch reads 0xFF, every pin is input-only (no pad drive enable is high), the analog-disable register reads 0x00, and every `padInEn` bit is 1.
- R2: The drive type of pin i is the code {cfgA[i],cfgB[i]}, where 00 is quasi-bidirectional, 01 is push-pull, 10 is input-only and 11 is open-drain. The code is evaluated per pin, independently of the other pins. cfgA is at address 2 and cfgB is at address 3.
- R3: In open-drain, `padPullDnEn[i]` equals the inverse of latch bit i, and both pull-up enables are 0.
- R4: In push-pull, `padPullDnEn[i]` is 1 when the latch bit is 0, and `padStrongUpEn[i]` is 1 when the latch bit is 1. The weak pull-up stays off.
- R5: In quasi-bidirectional, `padPullDnEn[i]` is 1 when the latch bit is 0, and `padWeakUpEn[i]` is 1 when the latch bit is 1. The strong pull-up stays off.
- R6: In input-only, all three drive enables are 0, whatever the latch holds.
- R7: Pin 5 is always input-only. Writes to cfgA bit 5 and cfgB bit 5 have no effect: cfgA bit 5 always reads 1 and cfgB bit 5 always reads 0.
- R8: On pins 2 and 3, codes 00 and 01 act as open-drain, code 11 is open-drain and code 10 is input-only. These pins never enable a pull-up.
- R9: The analog-disable register at address 4 stores only bits 1 to 5; all other bits read 0. `padInEn[i]` is the inverse of that register's bit i.
- R10: A read of address 1 returns `padIn` after a two-flop synchronizer, so a change shows in the read value two clock edges later. A pin whose digital input is disabled reads 0. Writes to address 1 are ignored.
- R11: The latch at address 0 reads back the value last written. Writes to the latch and to the configuration registers change the pad enables right after the writing clock edge.
- R12: Reads of addresses 5 to 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| padIn | input | 8 | Raw pad input samples |
| padPullDnEn | output | 8 | Strong pull-down enable per pin |
| padStrongUpEn | output | 8 | Strong pull-up enable per pin |
| padWeakUpEn | output | 8 | Weak pull-up enable per pin |
| padInEn | output | 8 | Digital input enable per pin |

## Verification
A corrupted configuration or latch bit shows up on the pad enables in the cycle right after the write that caused it. Examples are a pull-up on pin 2 or 3, drive on pin 5, or two drivers enabled at once on one pin. Restricted-mode errors are caught by writing every code to every pin and comparing all three enable vectors against a model built from the requirements. Synchronizer or gating errors surface on the pin read exactly two edges after a `padIn` change.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;
  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_LATCH = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_PIN   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CFGA  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CFGB  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_ANA   = 3'd4;

  typedef enum logic [1:0] {
    MODE_QUASI    = 2'b00,
    MODE_PUSHPULL = 2'b01,
    MODE_INPUT    = 2'b10,
    MODE_OPENDRN  = 2'b11
  } pinMode_e;

  typedef enum logic [2:0] {
    RD_LATCH, RD_PIN, RD_CFGA, RD_CFGB, RD_ANA, RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrLatch;
    logic   wrCfgA;
    logic   wrCfgB;
    logic   wrAna;
    rdSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  output portStrobe_t           strobe
);
  always_comb begin
    strobe = '{wrLatch: 1'b0, wrCfgA: 1'b0, wrCfgB: 1'b0, wrAna: 1'b0, rdSel: RD_NONE};
    unique case (busAddr)
      ADDR_LATCH: begin strobe.wrLatch = busWrEn; strobe.rdSel = RD_LATCH; end
      ADDR_PIN:   strobe.rdSel = RD_PIN;
      ADDR_CFGA:  begin strobe.wrCfgA = busWrEn; strobe.rdSel = RD_CFGA; end
      ADDR_CFGB:  begin strobe.wrCfgB = busWrEn; strobe.rdSel = RD_CFGB; end
      ADDR_ANA:   begin strobe.wrAna = busWrEn; strobe.rdSel = RD_ANA; end
      default:    strobe.rdSel = RD_NONE;
    endcase
  end

  // R12: unused addresses never raise a write strobe
  always_comb begin
    if (busAddr > ADDR_ANA)
      assert_no_stray_write_R12: assert (!(strobe.wrLatch | strobe.wrCfgA | strobe.wrCfgB | strobe.wrAna));
  end
endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] FIXED_IN    = 8'b0010_0000,
  parameter logic [WIDTH-1:0] OD_ONLY     = 8'b0000_1100,
  parameter logic [WIDTH-1:0] ANA_MASK    = 8'b0011_1110
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] pullDn,
  output logic [WIDTH-1:0] strongUp,
  output logic [WIDTH-1:0] weakUp,
  output logic [WIDTH-1:0] inEn
);
  logic [WIDTH-1:0] latchQ, cfgAQ, cfgBQ, anaDisQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= '1;
      cfgAQ   <= '1;
      cfgBQ   <= '0;
      anaDisQ <= '0;
    end else begin
      if (strobe.wrLatch) latchQ  <= wrData;
      if (strobe.wrCfgA)  cfgAQ   <= wrData | FIXED_IN;
      if (strobe.wrCfgB)  cfgBQ   <= wrData & ~FIXED_IN;
      if (strobe.wrAna)   anaDisQ <= wrData & ANA_MASK;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign inEn    = ~anaDisQ;
  assign pinRead = syncQ[SYNC_STAGES-1] & inEn;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pinMode_e effMode;
      always_comb begin
        if (FIXED_IN[i])
          effMode = MODE_INPUT;
        else if (OD_ONLY[i] && !cfgAQ[i])
          effMode = MODE_OPENDRN;
        else
          effMode = pinMode_e'({cfgAQ[i], cfgBQ[i]});
      end

      always_comb begin
        pullDn[i]   = (effMode != MODE_INPUT) && !latchQ[i];
        strongUp[i] = (effMode == MODE_PUSHPULL) && latchQ[i];
        weakUp[i]   = (effMode == MODE_QUASI) && latchQ[i];
      end

      assert_single_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0({pullDn[i], strongUp[i], weakUp[i]}));
      assert_pulldn_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
        pullDn[i] |-> !latchQ[i]);
      assert_gate_read_R10: assert property (@(posedge clk) disable iff (!rstN)
        !inEn[i] |-> !pinRead[i]);
      if (FIXED_IN[i]) begin : g_fixed
        assert_fixed_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
          !(pullDn[i] | strongUp[i] | weakUp[i]));
        assert_fixed_cfg_R7: assert property (@(posedge clk) disable iff (!rstN)
          strobe.wrCfgA |=> cfgAQ[i] && !cfgBQ[i]);
      end
      if (OD_ONLY[i]) begin : g_odonly
        assert_no_pullup_R8: assert property (@(posedge clk) disable iff (!rstN)
          !(strongUp[i] | weakUp[i]));
      end
      if (!ANA_MASK[i]) begin : g_noana
        assert_input_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
          inEn[i]);
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      RD_LATCH: rdData = latchQ;
      RD_PIN:   rdData = pinRead;
      RD_CFGA:  rdData = cfgAQ;
      RD_CFGB:  rdData = cfgBQ;
      RD_ANA:   rdData = anaDisQ;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpioPortCtl.sv
module gpioPortCtl
  import gpioPortPkg::*;
#(
  parameter int               WIDTH       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] FIXED_IN    = 8'b0010_0000,
  parameter logic [WIDTH-1:0] OD_ONLY     = 8'b0000_1100,
  parameter logic [WIDTH-1:0] ANA_MASK    = 8'b0011_1110
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [WIDTH-1:0]      busWrData,
  output logic [WIDTH-1:0]      busRdData,
  input  logic [WIDTH-1:0]      padIn,
  output logic [WIDTH-1:0]      padPullDnEn,
  output logic [WIDTH-1:0]      padStrongUpEn,
  output logic [WIDTH-1:0]      padWeakUpEn,
  output logic [WIDTH-1:0]      padInEn
);
  portStrobe_t strobe;

  gpioPortCtrl i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpioPortDatapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES),
    .FIXED_IN    (FIXED_IN),
    .OD_ONLY     (OD_ONLY),
    .ANA_MASK    (ANA_MASK)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .padIn    (padIn),
    .pullDn   (padPullDnEn),
    .strongUp (padStrongUpEn),
    .weakUp   (padWeakUpEn),
    .inEn     (padInEn)
  );
endmodule

// File: tb/test_gpioPortCtl.sv
module test_gpioPortCtl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData, padIn = '0;
  logic [7:0] padPullDnEn, padStrongUpEn, padWeakUpEn, padInEn;
  int total = 0, bad = 0;
  logic [7:0] mLatch = 8'hFF, mCfgA = 8'hFF, mCfgB = 8'h00;

  always #4 clk = ~clk;

  gpioPortCtl i_gpioPortCtl (.*);

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a == 3'd0) mLatch = d;
    if (a == 3'd2) mCfgA = d;
    if (a == 3'd3) mCfgB = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  // expected drive from R2..R8
  task automatic expectPads(input string tag);
    logic [7:0] dn, su, wu;
    dn = '0; su = '0; wu = '0;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] code;
      code = {mCfgA[i], mCfgB[i]};
      if (i == 5) code = 2'b10;
      if ((i == 2 || i == 3) && !code[1]) code = 2'b11;
      case (code)
        2'b00: begin dn[i] = !mLatch[i]; wu[i] = mLatch[i]; end
        2'b01: begin dn[i] = !mLatch[i]; su[i] = mLatch[i]; end
        2'b11: dn[i] = !mLatch[i];
        default: ;
      endcase
    end
    @(negedge clk);
    check8({tag, " pulldn"}, padPullDnEn, dn);
    check8({tag, " strongup"}, padStrongUpEn, su);
    check8({tag, " weakup"}, padWeakUpEn, wu);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); check8("R1 latch", d, 8'hFF);
    rd(3'd4, d); check8("R1 ana", d, 8'h00);
    check8("R1 inEn", padInEn, 8'hFF);
    expectPads("R1 idle");
    check8("R1 no drive", padPullDnEn | padStrongUpEn | padWeakUpEn, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'hA5);
    expectPads("R3 od A5");
    check8("R3 od pulldn", padPullDnEn, 8'h5A);
    wr(3'd0, 8'h3C); expectPads("R3 od 3C");
  endtask

  task automatic t_push_pull;
    wr(3'd2, 8'h00); wr(3'd3, 8'hFF); wr(3'd0, 8'hC3);
    expectPads("R4 pp C3");
    check8("R4 pp strong", padStrongUpEn, 8'hC3);
    wr(3'd0, 8'h18); expectPads("R11 latch to pad");
  endtask

  task automatic t_quasi;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h0F);
    expectPads("R5 quasi 0F");
    check8("R5 quasi weak", padWeakUpEn, 8'hC3 & 8'h0F & 8'hF3 | 8'h03);
  endtask

  task automatic t_input_only;
    wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
    wr(3'd0, 8'h00); expectPads("R6 in lo");
    wr(3'd0, 8'hFF); expectPads("R6 in hi");
  endtask

  task automatic t_mixed;
    for (int c = 0; c < 4; c++) begin
      wr(3'd2, c[1] ? 8'hAA : 8'h55); wr(3'd3, c[0] ? 8'hCC : 8'h33);
      wr(3'd0, 8'h69); expectPads("R2 mixed a");
      wr(3'd0, 8'h96); expectPads("R2 mixed b");
    end
  endtask

  task automatic t_fixed_pin;
    logic [7:0] d;
    wr(3'd2, 8'h00); wr(3'd3, 8'hFF); wr(3'd0, 8'h20);
    expectPads("R7 pp");
    check8("R7 pin5 quiet", {7'b0, padPullDnEn[5] | padStrongUpEn[5] | padWeakUpEn[5]}, 8'h00);
    rd(3'd2, d); check8("R7 cfgA rb", d, 8'h20);
    rd(3'd3, d); check8("R7 cfgB rb", d, 8'hDF);
    wr(3'd0, 8'h00); expectPads("R7 latch0");
  endtask

  task automatic t_restricted;
    for (int c = 0; c < 4; c++) begin
      wr(3'd2, c[1] ? 8'hFF : 8'h00); wr(3'd3, c[0] ? 8'hFF : 8'h00);
      wr(3'd0, 8'h0C); expectPads("R8 hi");
      check8("R8 no pullup", (padStrongUpEn | padWeakUpEn) & 8'h0C, 8'h00);
      wr(3'd0, 8'h00); expectPads("R8 lo");
    end
  endtask

  task automatic t_analog_and_pin;
    logic [7:0] d;
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check8("R9 ana mask", d, 8'h3E);
    check8("R9 inEn", padInEn, 8'hC1);
    @(negedge clk); padIn = 8'hFF;
    @(negedge clk); busAddr = 3'd1; #1 check8("R10 one edge", busRdData, 8'h00);
    @(negedge clk); #1 check8("R10 gated", busRdData, 8'hC1);
    wr(3'd4, 8'h00);
    rd(3'd1, d); check8("R10 ungated", d, 8'hFF);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check8("R10 write ignored", d, 8'hFF);
    @(negedge clk); padIn = 8'h5A;
    @(negedge clk); @(negedge clk); #1 check8("R10 pattern", busRdData, 8'h5A);
  endtask

  task automatic t_latch_and_bad;
    logic [7:0] d;
    wr(3'd0, 8'h93); rd(3'd0, d); check8("R11 latch rb", d, 8'h93);
    wr(3'd6, 8'h00); wr(3'd7, 8'h00); wr(3'd5, 8'h00);
    rd(3'd0, d); check8("R12 latch kept", d, 8'h93);
    rd(3'd2, d); check8("R12 cfgA kept", d, mCfgA | 8'h20);
    rd(3'd5, d); check8("R12 read 5", d, 8'h00);
    rd(3'd7, d); check8("R12 read 7", d, 8'h00);
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_open_drain();
    t_push_pull();
    t_quasi();
    t_input_only();
    t_mixed();
    t_fixed_pin();
    t_restricted();
    t_analog_and_pin();
    t_latch_and_bad();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule